// File: doc/BRIEF.md
# Serial BCH(31,16) Parity Encoder

This block computes the 15 check bits of the binary BCH(31,16) code one bit per clock. A 16-bit message is captured when `start` is asserted while the encoder is idle. The message is then shifted, most significant bit first, into a 15-bit polynomial-division register, followed by fifteen zero bits. After the last bit the register holds the remainder of m(x)·x^15 divided by the generator g(x) = x^15 + x^11 + x^10 + x^9 + x^8 + x^7 + x^5 + x^3 + x^2 + x + 1.

A full encode takes 31 clocks after the accepted start. The block then raises `done` for one cycle. It presents the parity bits and the systematic codeword, with the message in the upper field and the check bits in the lower field. Both results stay on the outputs until the next accepted start. Reset is synchronous and active high.

Top module: `bch_serial_enc`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself: after that edge `busy`, `done`, `parity` and `codeword` all read zero.
- R2: A `start` sampled high while `busy` is low is accepted. In the next cycle `busy` is high and `parity` reads zero, because the division register has been cleared.
- R3: When `done` is high, `parity` equals the remainder of m(x)·x^15 modulo g(x). Message bit 15 is the coefficient of x^15 in m(x). Parity bit 14 is the coefficient of x^14 and bit 0 is the constant term. In the tap vector on bits 14..0 (000111110101111), a one marks each place where the outgoing top bit is fed back.
- R4: When `done` is high, `codeword[30:15]` equals the accepted message and `codeword[14:0]` equals `parity`.
- R5: `done` rises exactly 31 clock edges after the edge that accepted `start`. `busy` is high for exactly the 31 cycles in between.
- R6: `done` is a single-cycle pulse, and `busy` is low in the cycle where `done` is high.
- R7: While `busy` is low and `start` is low, `parity` and `codeword` keep their values.
- R8: A `start` seen while `busy` is high is ignored. The running message, the timing and the final result are the same as if that start had not occurred.
- R9: The message 0x0041 encodes to parity 100101000100010 (0x4A22).
- R10: A `start` given in the same cycle that `done` is high is accepted like any other idle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to encode `msg_in`; honoured only when idle |
| msg_in | input | 16 | Message word captured on an accepted start |
| busy | output | 1 | High while the 31 bits are being shifted |
| done | output | 1 | One-cycle pulse when the result is ready |
| parity | output | 15 | Division remainder (check bits) |
| codeword | output | 31 | Message in bits 30:15, check bits in bits 14:0 |

## Verification
Two pairs of functions can land on the same edge. First, the final shift that raises `done` can coincide with a new request: the bench issues every encode of its sweep in the very cycle the previous `done` is visible. It judges the result by the new message's remainder, by a cleared register one cycle later, and by 31-edge timing again. Second, a request can arrive in the middle of a running shift. Some runs inject a start with a different message part-way through, and the completed codeword must still match the original message's model remainder, which the bench computes by plain GF(2) long division.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
   // Code dimensions and generator tap vector (bits 14..0, x^15 implied).
   localparam int unsigned  BCH_MSG_W   = 16;
   localparam int unsigned  BCH_PAR_W   = 15;
   localparam logic [14:0]  BCH_GEN_TAP = 15'b000111110101111;

   typedef enum logic [0:0] {
      ENC_IDLE  = 1'b0,
      ENC_SHIFT = 1'b1
   } enc_state_e;
endpackage

// File: rtl/bch_piso.sv
module bch_piso #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             shift,
   input  logic [WIDTH-1:0] din,
   output logic             bit_out
);
   logic [WIDTH-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (rst)
         sh_q <= '0;
      else if (load)
         sh_q <= din;
      else if (shift)
         sh_q <= {sh_q[WIDTH-2:0], 1'b0};
   end

   assign bit_out = sh_q[WIDTH-1];
endmodule

// File: rtl/bch_lfsr_div.sv
module bch_lfsr_div #(
   parameter int unsigned       DEG  = 15,
   parameter logic [DEG-1:0]    TAPS = '1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           clear,
   input  logic           step,
   input  logic           din,
   output logic [DEG-1:0] rem
);
   logic [DEG-1:0] st_q;
   logic [DEG-1:0] st_d;
   logic           fb;

   assign fb = st_q[DEG-1];

   for (genvar i = 0; i < DEG; i++) begin : g_cell
      if (i == 0) begin : g_head
         assign st_d[i] = din ^ (TAPS[i] & fb);
      end else begin : g_body
         assign st_d[i] = st_q[i-1] ^ (TAPS[i] & fb);
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clear)
         st_q <= '0;
      else if (step)
         st_q <= st_d;
   end

   assign rem = st_q;
endmodule

// File: rtl/bch_enc_seq.sv
module bch_enc_seq
   import bch_enc_pkg::*;
#(
   parameter int unsigned STEPS = 31
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic accept,
   output logic step,
   output logic busy,
   output logic done
);
   localparam int unsigned CNT_W = $clog2(STEPS + 1);

   enc_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   assign accept = start && (st_q == ENC_IDLE);
   assign step   = (st_q == ENC_SHIFT);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ENC_IDLE;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            st_q  <= ENC_SHIFT;
            cnt_q <= CNT_W'(STEPS);
         end else if (step) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               st_q   <= ENC_IDLE;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy = (st_q == ENC_SHIFT);
   assign done = done_q;
endmodule

// File: rtl/bch_serial_enc.sv
module bch_serial_enc
   import bch_enc_pkg::*;
#(
   parameter int unsigned          MSG_W = BCH_MSG_W,
   parameter int unsigned          PAR_W = BCH_PAR_W,
   parameter logic [PAR_W-1:0]     TAPS  = BCH_GEN_TAP
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [MSG_W-1:0]       msg_in,
   output logic                   busy,
   output logic                   done,
   output logic [PAR_W-1:0]       parity,
   output logic [MSG_W+PAR_W-1:0] codeword
);
   localparam int unsigned STEPS = MSG_W + PAR_W;

   if (MSG_W < 2) begin : g_chk_msg
      $error("bch_serial_enc: MSG_W must be at least 2");
   end
   if (PAR_W < 2) begin : g_chk_par
      $error("bch_serial_enc: PAR_W must be at least 2");
   end
   if (TAPS[0] != 1'b1) begin : g_chk_tap
      $error("bch_serial_enc: generator constant term must be one");
   end

   logic             accept;
   logic             step;
   logic             ser_bit;
   logic [MSG_W-1:0] msg_q;

   bch_enc_seq #(.STEPS(STEPS)) i_seq (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .accept (accept),
      .step   (step),
      .busy   (busy),
      .done   (done)
   );

   bch_piso #(.WIDTH(MSG_W)) i_piso (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .shift   (step),
      .din     (msg_in),
      .bit_out (ser_bit)
   );

   bch_lfsr_div #(.DEG(PAR_W), .TAPS(TAPS)) i_div (
      .clk   (clk),
      .rst   (rst),
      .clear (accept),
      .step  (step),
      .din   (ser_bit),
      .rem   (parity)
   );

   always_ff @(posedge clk) begin
      if (rst)
         msg_q <= '0;
      else if (accept)
         msg_q <= msg_in;
   end

   assign codeword = {msg_q, parity};
endmodule

// File: rtl/bch_serial_enc_chk.sv
module bch_serial_enc_chk #(
   parameter int unsigned MSG_W = 16,
   parameter int unsigned PAR_W = 15
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   start,
   input logic                   busy,
   input logic                   done,
   input logic [PAR_W-1:0]       parity,
   input logic [MSG_W+PAR_W-1:0] codeword
);
   localparam int unsigned STEPS = MSG_W + PAR_W;
   localparam int unsigned CW    = $clog2(STEPS + 2);

   logic [CW-1:0] busy_cyc;

   always_ff @(posedge clk) begin
      if (rst)
         busy_cyc <= '0;
      else if (start && !busy)
         busy_cyc <= '0;
      else if (busy)
         busy_cyc <= busy_cyc + 1'b1;
   end

   p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> (busy && parity == '0));

   p_codeword_split_r4: assert property (@(posedge clk) disable iff (rst)
      done |-> (codeword[PAR_W-1:0] == parity));

   p_busy_length_r5: assert property (@(posedge clk) disable iff (rst)
      done |-> (busy_cyc == CW'(STEPS)));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy ##1 !done));

   p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> ($stable(parity) && $stable(codeword)));

   p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> $stable(codeword[MSG_W+PAR_W-1:PAR_W]));
endmodule

bind bch_serial_enc bch_serial_enc_chk #(.MSG_W(MSG_W), .PAR_W(PAR_W)) i_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .parity   (parity),
   .codeword (codeword)
);

// File: tb/test_bch_serial_enc.sv
`timescale 1ns/1ps
module test_bch_serial_enc;
   localparam int MW = 16;
   localparam int PW = 15;
   localparam logic [14:0] GTAP = 15'b000111110101111;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [MW-1:0] msg_in = '0;
   logic          busy;
   logic          done;
   logic [PW-1:0] parity;
   logic [MW+PW-1:0] codeword;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   bch_serial_enc i_bch_serial_enc (
      .clk(clk), .rst(rst), .start(start), .msg_in(msg_in),
      .busy(busy), .done(done), .parity(parity), .codeword(codeword)
   );

   // GF(2) long division of m(x)*x^15 by g(x), feedback-point form.
   function automatic logic [14:0] model_rem(input logic [15:0] m);
      logic [14:0] r = '0;
      for (int i = 15; i >= 0; i--) begin
         logic fb = r[14] ^ m[i];
         r = {r[13:0], 1'b0} ^ (fb ? GTAP : 15'd0);
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called mid-cycle; returns mid-cycle in the cycle where done is high.
   task automatic encode(input logic [15:0] m, input int inject_at, input logic [15:0] other);
      logic [14:0] exp_p = model_rem(m);
      start = 1'b1; msg_in = m;
      @(posedge clk); #1;
      start = 1'b0;
      chk(busy === 1'b1 && parity === 15'd0, "R2", {busy, parity}, {1'b1, 15'd0});
      for (int n = 1; n <= 31; n++) begin
         if (n == inject_at) begin
            start = 1'b1; msg_in = other;
         end
         @(posedge clk); #1;
         start = 1'b0;
         if (n == 30) chk(done === 1'b0 && busy === 1'b1, "R5", {busy, done}, 2'b10);
      end
      chk(done === 1'b1, "R5", done, 1);
      chk(busy === 1'b0, "R6", busy, 0);
      chk(parity === exp_p, inject_at > 0 ? "R8" : "R3", parity, exp_p);
      chk(codeword === {m, exp_p}, "R4", codeword, {m, exp_p});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk(busy === 0 && done === 0 && parity === 0 && codeword === 0, "R1",
          {busy, done, parity, codeword}, 0);
      rst = 1'b0;

      // R9 known vector
      encode(16'h0041, 0, 16'h0);
      chk(parity === 15'h4A22, "R9", parity, 15'h4A22);

      // R7 hold while idle, done stays low
      repeat (5) @(posedge clk);
      #1;
      chk(parity === 15'h4A22 && codeword === {16'h0041, 15'h4A22} && done === 0,
          "R7", {done, codeword}, {1'b0, 16'h0041, 15'h4A22});

      // R8 start injected mid-run at several points
      encode(16'hBEEF, 10, 16'h1234);
      encode(16'h8001, 1, 16'hFFFF);
      encode(16'h7F00, 31, 16'h0F0F);

      // corner messages and walking ones; each start falls in the done cycle (R10)
      encode(16'h0000, 0, 16'h0);
      chk(parity === 15'd0, "R10", parity, 0);
      encode(16'hFFFF, 0, 16'h0);
      for (int b = 0; b < 16; b++) encode(16'h1 << b, 0, 16'h0);

      // sweep
      for (int k = 0; k < 3000; k++) encode(16'(k * 21) ^ 16'(k << 7), 0, 16'h0);

      // R10: back-to-back start accepted and cleared the register
      start = 1'b1; msg_in = 16'h0041;
      @(posedge clk); #1;
      start = 1'b0;
      chk(busy === 1'b1 && parity === 15'd0, "R10", {busy, parity}, {1'b1, 15'd0});
      repeat (31) @(posedge clk);
      #1;
      chk(done === 1'b1 && parity === 15'h4A22, "R10", {done, parity}, {1'b1, 15'h4A22});

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule